// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Engine

This block is the bus-facing half of a 256-byte serial EEPROM. A fast system clock samples the two-wire bus lines. Each line goes through a synchronizer and a stability filter. The engine then finds START and STOP conditions and compares the control byte with its chip-select inputs. It drives SDA as an open-drain output: asserting `sda_pull` pulls the line low. A word pointer survives from one transaction to the next, so a read sent without a word address continues from where the last access stopped.

Accepted write data leaves the engine as a stream of address/data beats. A separate page-buffer and write-cycle sequencer takes them, and a one-cycle commit strobe tells it to start programming. While that sequencer reports busy, the engine refuses its own control byte, so a master can poll for completion. Read data comes from a synchronous memory port with one cycle of latency.

The push interface uses valid/ready. `wr_valid` is raised only in a cycle where `wr_ready` is already high, so every beat completes in the cycle it is offered. If the sequencer holds `wr_ready` low, the engine does not wait for it: it answers that data byte with NACK and offers nothing. The write-protect, busy and chip-select inputs are plain levels.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: A bus line level change is accepted only after the synchronized input has held the new level for FILT_N consecutive system clocks. An SDA dip shorter than that while SCL is high is not taken as a START and does not disturb the byte in flight.
- R2: The control byte is sent MSB first. Bits 7..4 must be 1010 and bits 3..1 must equal `chip_sel`. Bit 0 = 1 selects read and bit 0 = 0 selects write. The engine acknowledges by pulling SDA low through the ninth SCL pulse, and only on a match.
- R3: While `wr_busy` is high, a matching control byte gets no acknowledge.
- R4: In a write transaction the first byte after the control byte loads the word pointer and is always acknowledged. Each following byte is offered on `wr_valid` with `wr_addr` equal to the pointer and `wr_data` equal to the byte, and then acknowledged. If `wr_ready` is low, the byte is refused with NACK and no beat is offered.
- R5: After each accepted data byte, only the low PAGE_W bits of the word pointer increment. They wrap inside the page and the upper bits stay fixed.
- R6: After one or more beats have been accepted, `wr_commit` pulses for one cycle on the next START or STOP. A transaction with no accepted beat produces no commit.
- R7: While `wp` is high, the control byte and the word address are still acknowledged. The first data byte is refused, no beat is offered and no commit follows.
- R8: A read control byte with no word address before it returns the byte at the current pointer. That pointer is one past the last location read or written.
- R9: A repeated START after the word address ends the write phase and keeps the new pointer. A read control byte that follows returns data from that address.
- R10: In a read, a master ACK makes the engine send the next byte from the incremented pointer. The pointer wraps from 255 to 0.
- R11: After a master NACK, the engine leaves SDA released until the next START.
- R12: A START or STOP in the middle of a byte abandons it. After a STOP, bytes clocked without a new START get no acknowledge.
- R13: `sda_pull` is low out of reset and changes only while the filtered SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Raw bus clock level |
| sda_in | input | 1 | Raw bus data level (wired line) |
| sda_pull | output | 1 | High pulls SDA low |
| chip_sel | input | 3 | Chip-select value compared with control bits 3..1 |
| wp | input | 1 | Write protect level |
| wr_busy | input | 1 | Sequencer is in an internal write cycle |
| wr_valid | output | 1 | Write beat offered |
| wr_ready | input | 1 | Sequencer can take a beat |
| wr_addr | output | 8 | Byte address of the beat |
| wr_data | output | 8 | Data of the beat |
| wr_commit | output | 1 | One-cycle strobe: program the pushed beats |
| rd_en | output | 1 | Memory read request |
| rd_addr | output | 8 | Memory read address |
| rd_data | input | 8 | Read data, valid the cycle after rd_en |

## Verification
The assertions assume a master that obeys the bus rules. SDA changes only while SCL is low, except at START and STOP, and the master never issues START or STOP while the engine holds SDA low. They also assume the sequencer holds `wr_ready` steady during the decision cycle. The bench master keeps these rules on every path except the deliberate glitch, which is shorter than FILT_N. It moves SDA a quarter SCL period after each SCL edge, so every level lasts well beyond the filter window. Its SCL is slow enough that a read fetch is loaded long before the bit that uses it.

// File: rtl/i2c_ee_pkg.sv
package i2c_ee_pkg;
  localparam int BYTE_W  = 8;
  localparam int SEL_W   = 3;
  localparam int CODE_W  = BYTE_W - SEL_W - 1;
  localparam logic [CODE_W-1:0] DEV_CODE = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CTRL,
    ST_ADDR,
    ST_WDATA,
    ST_RDATA
  } ee_state_t;
endpackage

// File: rtl/i2c_glitch_filt.sv
module i2c_glitch_filt #(
  parameter int FILT_N = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic line_out
);
  localparam int CW = $clog2(FILT_N + 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] run_q;
  logic          out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b11;
      run_q  <= '0;
      out_q  <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], line_in};
      if (sync_q[1] == out_q) begin
        run_q <= '0;
      end else if (run_q == CW'(FILT_N - 1)) begin
        out_q <= sync_q[1];
        run_q <= '0;
      end else begin
        run_q <= run_q + CW'(1);
      end
    end
  end

  assign line_out = out_q;

  // R1: a new filtered level always equals the synchronized level that preceded it
  p_filt_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(out_q) |-> out_q == $past(sync_q[1]));
endmodule

// File: rtl/i2c_bus_cond.sv
module i2c_bus_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f,
  input  logic sda_f,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_f;
      sda_p <= sda_f;
    end
  end

  assign scl_rise  = scl_f & ~scl_p;
  assign scl_fall  = ~scl_f & scl_p;
  assign start_det = scl_f & scl_p & sda_p & ~sda_f;
  assign stop_det  = scl_f & scl_p & ~sda_p & sda_f;
endmodule

// File: rtl/i2c_ee_core.sv
module i2c_ee_core
  import i2c_ee_pkg::*;
#(
  parameter int PAGE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_f,
  input  logic              sda_f,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [SEL_W-1:0]  chip_sel,
  input  logic              wp,
  input  logic              wr_busy,
  output logic              sda_pull,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [BYTE_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic              wr_commit,
  output logic              rd_en,
  output logic [BYTE_W-1:0] rd_addr,
  input  logic [BYTE_W-1:0] rd_data
);
  ee_state_t         state_q, nxt_q;
  logic [3:0]        cnt_q;
  logic              ack_ph_q, pull_q, m_ack_q, pend_q, rd_en_q, load_q, commit_q;
  logic [BYTE_W-1:0] rx_q, tx_q, ptr_q, ptr_page_inc;
  logic              addr_hit, byte_ack, decide, bus_evt;

  assign bus_evt  = start_det | stop_det;
  assign decide   = scl_fall & ~ack_ph_q & (cnt_q == 4'd8) & ~bus_evt;
  assign addr_hit = rx_q[BYTE_W-1:1] == {DEV_CODE, chip_sel};
  assign ptr_page_inc = {ptr_q[BYTE_W-1:PAGE_W], ptr_q[PAGE_W-1:0] + PAGE_W'(1)};

  always_comb begin
    case (state_q)
      ST_CTRL:  byte_ack = addr_hit & ~wr_busy;
      ST_ADDR:  byte_ack = 1'b1;
      ST_WDATA: byte_ack = ~wp & wr_ready;
      default:  byte_ack = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      nxt_q    <= ST_IDLE;
      cnt_q    <= '0;
      ack_ph_q <= 1'b0;
      pull_q   <= 1'b0;
      m_ack_q  <= 1'b0;
      pend_q   <= 1'b0;
      rd_en_q  <= 1'b0;
      load_q   <= 1'b0;
      commit_q <= 1'b0;
      rx_q     <= '0;
      tx_q     <= '1;
      ptr_q    <= '0;
    end else begin
      rd_en_q  <= 1'b0;
      commit_q <= 1'b0;
      load_q   <= rd_en_q;
      if (load_q) tx_q <= rd_data;
      if (bus_evt) begin
        pull_q   <= 1'b0;
        cnt_q    <= '0;
        ack_ph_q <= 1'b0;
        state_q  <= start_det ? ST_CTRL : ST_IDLE;
        if (pend_q) begin
          commit_q <= 1'b1;
          pend_q   <= 1'b0;
        end
      end else begin
        case (state_q)
          ST_CTRL, ST_ADDR, ST_WDATA: begin
            if (scl_rise && !ack_ph_q && cnt_q != 4'd8) begin
              rx_q  <= {rx_q[BYTE_W-2:0], sda_f};
              cnt_q <= cnt_q + 4'd1;
            end else if (decide) begin
              ack_ph_q <= 1'b1;
              pull_q   <= byte_ack;
              case (state_q)
                ST_CTRL: begin
                  nxt_q <= rx_q[0] ? ST_RDATA : ST_ADDR;
                  if (byte_ack && rx_q[0]) rd_en_q <= 1'b1;
                end
                ST_ADDR: begin
                  nxt_q <= ST_WDATA;
                  ptr_q <= rx_q;
                end
                default: begin
                  nxt_q <= ST_WDATA;
                  if (byte_ack) begin
                    ptr_q  <= ptr_page_inc;
                    pend_q <= 1'b1;
                  end
                end
              endcase
            end else if (scl_fall && ack_ph_q) begin
              ack_ph_q <= 1'b0;
              cnt_q    <= '0;
              if (!pull_q) begin
                state_q <= ST_IDLE;
              end else if (nxt_q == ST_RDATA) begin
                pull_q  <= ~tx_q[BYTE_W-1];
                state_q <= ST_RDATA;
              end else begin
                pull_q  <= 1'b0;
                state_q <= nxt_q;
              end
            end
          end
          ST_RDATA: begin
            if (!ack_ph_q) begin
              if (scl_rise && cnt_q != 4'd8) begin
                cnt_q <= cnt_q + 4'd1;
              end else if (scl_fall && cnt_q != 4'd0 && cnt_q != 4'd8) begin
                pull_q <= ~tx_q[BYTE_W-2];
                tx_q   <= {tx_q[BYTE_W-2:0], 1'b1};
              end else if (scl_fall && cnt_q == 4'd8) begin
                pull_q   <= 1'b0;
                ack_ph_q <= 1'b1;
                ptr_q    <= ptr_q + 8'd1;
              end
            end else begin
              if (scl_rise) begin
                m_ack_q <= ~sda_f;
                if (!sda_f) rd_en_q <= 1'b1;
              end else if (scl_fall) begin
                ack_ph_q <= 1'b0;
                cnt_q    <= '0;
                if (m_ack_q) pull_q <= ~tx_q[BYTE_W-1];
                else         state_q <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_pull  = pull_q;
  assign wr_valid  = decide & (state_q == ST_WDATA) & byte_ack;
  assign wr_addr   = ptr_q;
  assign wr_data   = rx_q;
  assign wr_commit = commit_q;
  assign rd_en     = rd_en_q;
  assign rd_addr   = ptr_q;

  // R13: open-drain output only moves while the bus clock is low
  p_pull_scl_low_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pull_q) |-> !scl_f);
  // R4: a beat is only offered into a ready sink
  p_push_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> wr_ready);
  // R4: an accepted beat is acknowledged on the bus
  p_push_acked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> sda_pull);
  // R7: nothing is pushed under write protect
  p_wp_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> !wp);
  // R3: busy sequencer means the control byte is not acknowledged
  p_busy_nack_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CTRL && decide && wr_busy) |=> !sda_pull);
  // R6: commit is a single-cycle strobe
  p_commit_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |=> !wr_commit);
  // R10: read address holds while the fetched data returns
  p_rd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> $stable(rd_addr));
endmodule

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave
  import i2c_ee_pkg::*;
#(
  parameter int PAGE_W = 3,
  parameter int FILT_N = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       sda_pull,
  input  logic [2:0] chip_sel,
  input  logic       wp,
  input  logic       wr_busy,
  output logic       wr_valid,
  input  logic       wr_ready,
  output logic [7:0] wr_addr,
  output logic [7:0] wr_data,
  output logic       wr_commit,
  output logic       rd_en,
  output logic [7:0] rd_addr,
  input  logic [7:0] rd_data
);
  logic [1:0] raw, filt;
  logic scl_rise, scl_fall, start_det, stop_det;

  assign raw = {scl_in, sda_in};

  for (genvar g = 0; g < 2; g++) begin : g_filt
    i2c_glitch_filt #(.FILT_N(FILT_N)) u_filt (
      .clk      (clk),
      .rst_n    (rst_n),
      .line_in  (raw[g]),
      .line_out (filt[g])
    );
  end

  i2c_bus_cond u_cond (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_f     (filt[1]),
    .sda_f     (filt[0]),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2c_ee_core #(.PAGE_W(PAGE_W)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_f     (filt[1]),
    .sda_f     (filt[0]),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .chip_sel  (chip_sel),
    .wp        (wp),
    .wr_busy   (wr_busy),
    .sda_pull  (sda_pull),
    .wr_valid  (wr_valid),
    .wr_ready  (wr_ready),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .wr_commit (wr_commit),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data)
  );
endmodule

// File: tb/tb_i2c_eeprom_slave.sv
module tb_i2c_eeprom_slave;
  localparam int Q    = 20;
  localparam int BUSY = 2000;
  localparam logic [2:0] SEL = 3'b101;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, glitch_low = 1'b0;
  logic [2:0] chip_sel = SEL;
  logic wp = 1'b0, wr_ready = 1'b1, wr_busy;
  logic sda_pull, wr_valid, wr_commit, rd_en;
  logic [7:0] wr_addr, wr_data, rd_addr, rd_data;
  wire sda_line = sda_m & ~sda_pull & ~glitch_low;

  i2c_eeprom_slave dut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
    .sda_pull(sda_pull), .chip_sel(chip_sel), .wp(wp), .wr_busy(wr_busy),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_commit(wr_commit), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  // sequencer and memory model
  logic [7:0] mem [256];
  logic [7:0] expm [256];
  logic [7:0] lg_a [64];
  logic [7:0] lg_d [64];
  int lg_n = 0, pend_base = 0, commit_n = 0, busy_cnt = 0;
  assign wr_busy = (busy_cnt != 0);

  initial for (int i = 0; i < 256; i++) begin
    mem[i]  = 8'((i * 37 + 11) & 255);
    expm[i] = 8'((i * 37 + 11) & 255);
  end

  always @(posedge clk) begin
    if (busy_cnt != 0) busy_cnt = busy_cnt - 1;
    if (wr_valid && wr_ready && lg_n < 64) begin
      lg_a[lg_n] = wr_addr;
      lg_d[lg_n] = wr_data;
      lg_n = lg_n + 1;
    end
    if (wr_commit) begin
      for (int k = pend_base; k < lg_n; k++) mem[lg_a[k]] = lg_d[k];
      pend_base = lg_n;
      commit_n  = commit_n + 1;
      busy_cnt  = BUSY;
    end
    if (rd_en) rd_data <= mem[rd_addr];
  end

  int n_chk = 0, n_fail = 0;
  logic timeout = 1'b0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(2*Q);
    sda_m = 1'b0; tick(2*Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(2*Q); sda_m = 1'b1; tick(2*Q);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n, input int glitch_bit);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; tick(Q); scl_m = 1'b1; tick(Q);
      if (i == glitch_bit) begin glitch_low = 1'b1; tick(2); glitch_low = 1'b0; tick(Q-2); end
      else tick(Q);
      scl_m = 1'b0; tick(Q);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    send_bits(b, 8, -1);
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
    acked = !sda_line; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q); scl_m = 1'b1; tick(Q); b[i] = sda_line; tick(Q); scl_m = 1'b0; tick(Q);
    end
    sda_m = !mack; tick(Q); scl_m = 1'b1; tick(2*Q); scl_m = 1'b0; tick(Q);
    sda_m = 1'b1;
  endtask

  function automatic logic [7:0] ctrl(input logic rw);
    return {4'b1010, SEL, rw};
  endfunction

  task automatic wait_idle();
    logic a;
    for (int t = 0; t < 20; t++) begin
      bus_start(); send_byte(ctrl(1'b0), a); bus_stop();
      if (a) break;
    end
  endtask

  task automatic random_read(input logic [7:0] a, input int n, input string req);
    logic ak; logic [7:0] d;
    bus_start(); send_byte(ctrl(1'b0), ak); send_byte(a, ak);
    bus_start(); send_byte(ctrl(1'b1), ak);
    check({req, " read ctrl ack"}, ak, 1);
    for (int k = 0; k < n; k++) begin
      recv_byte(k != n - 1, d);
      check({req, " read data"}, d, expm[8'(a + k)]);
    end
  endtask

  task automatic run_all();
    logic ak; logic [7:0] d; int base_n, base_c;
    tick(5);
    // R13: released and quiet out of reset
    check("R13 reset", {sda_pull, wr_valid, rd_en, wr_commit}, 0);
    rst_n = 1'b1; tick(10);

    // R2: sweep every chip-select value, plus a wrong device code
    base_c = commit_n;
    for (int s = 0; s < 8; s++) begin
      bus_start(); send_byte({4'b1010, 3'(s), 1'b0}, ak); bus_stop();
      check("R2 chip select match", ak, (s == SEL));
    end
    bus_start(); send_byte({4'b1011, SEL, 1'b1}, ak); bus_stop();
    check("R2 wrong device code", ak, 0);
    check("R6 no commit without beats", commit_n, base_c);

    // R4 R6: byte write
    base_n = lg_n; base_c = commit_n;
    bus_start(); send_byte(ctrl(1'b0), ak); send_byte(8'h20, ak);
    check("R4 word address ack", ak, 1);
    send_byte(8'hC3, ak);
    check("R4 data ack", ak, 1);
    bus_stop();
    expm[8'h20] = 8'hC3;
    check("R4 one beat", lg_n - base_n, 1);
    check("R4 beat addr", lg_a[base_n], 8'h20);
    check("R4 beat data", lg_d[base_n], 8'hC3);
    check("R6 commit after stop", commit_n - base_c, 1);
    // R3: poll while busy
    bus_start(); send_byte(ctrl(1'b0), ak); bus_stop();
    check("R3 busy nack", ak, 0);
    wait_idle();
    check("R3 ack after busy", wr_busy, 0);
    // R8: current address read continues one past the write
    bus_start(); send_byte(ctrl(1'b1), ak); recv_byte(1'b0, d); bus_stop();
    check("R8 current read", d, expm[8'h21]);

    // R5: page write of ten bytes from 0x3E wraps inside the 8-byte page
    base_n = lg_n;
    bus_start(); send_byte(ctrl(1'b0), ak); send_byte(8'h3E, ak);
    for (int i = 0; i < 10; i++) begin
      send_byte(8'h90 + 8'(i), ak);
      check("R5 page data ack", ak, 1);
    end
    bus_stop();
    for (int i = 0; i < 10; i++) begin
      logic [7:0] ea;
      ea = {5'b00111, 3'(6 + i)};
      check("R5 page addr", lg_a[base_n + i], ea);
      check("R5 page data", lg_d[base_n + i], 8'h90 + 8'(i));
      expm[ea] = 8'h90 + 8'(i);
    end
    wait_idle();
    bus_start(); send_byte(ctrl(1'b1), ak); recv_byte(1'b0, d); bus_stop();
    check("R8 current read after page", d, expm[8'h38]);

    // R9 R10: random reads with sequential continuation, including 255->0 wrap
    random_read(8'h00, 4, "R9");
    random_read(8'h3C, 4, "R10");
    random_read(8'hFD, 5, "R10 wrap");
    // R11: after master NACK the line stays released for another clock
    tick(Q); scl_m = 1'b1; tick(Q);
    check("R11 released after nack", sda_line, 1);
    tick(Q); scl_m = 1'b0; tick(Q);
    bus_stop();
    bus_start(); send_byte(ctrl(1'b1), ak); recv_byte(1'b0, d); bus_stop();
    check("R8 current after wrap", d, expm[8'h02]);

    // R7: write protect
    wp = 1'b1; base_n = lg_n; base_c = commit_n;
    bus_start(); send_byte(ctrl(1'b0), ak);
    check("R7 ctrl ack under wp", ak, 1);
    send_byte(8'h50, ak);
    check("R7 addr ack under wp", ak, 1);
    send_byte(8'h11, ak);
    check("R7 data nack under wp", ak, 0);
    bus_stop();
    check("R7 no beat", lg_n, base_n);
    check("R7 no commit", commit_n, base_c);
    wp = 1'b0;
    random_read(8'h50, 1, "R7");
    bus_stop();

    // R4: sink not ready
    wr_ready = 1'b0; base_n = lg_n;
    bus_start(); send_byte(ctrl(1'b0), ak); send_byte(8'h60, ak); send_byte(8'h22, ak);
    bus_stop();
    check("R4 nack when not ready", ak, 0);
    check("R4 no beat when not ready", lg_n, base_n);
    wr_ready = 1'b1;

    // R12: aborts
    bus_start(); send_bits(ctrl(1'b0), 4, -1); bus_stop();
    send_byte(ctrl(1'b0), ak);
    check("R12 no ack without start", ak, 0);
    bus_stop();
    bus_start(); send_bits(ctrl(1'b0), 5, -1); bus_start();
    send_byte(ctrl(1'b0), ak); bus_stop();
    check("R12 restart after partial byte", ak, 1);

    // R1: a short SDA dip while SCL is high is not a START
    base_n = lg_n;
    bus_start(); send_byte(ctrl(1'b0), ak); send_byte(8'h10, ak);
    send_bits(8'hFF, 8, 3);
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q); ak = !sda_line; tick(Q); scl_m = 1'b0; tick(Q);
    bus_stop();
    check("R1 glitch byte ack", ak, 1);
    check("R1 glitch beat data", lg_d[base_n], 8'hFF);
    check("R1 glitch beat addr", lg_a[base_n], 8'h10);
  endtask

  initial begin
    fork
      run_all();
      begin repeat (190000) @(posedge clk); timeout = 1'b1; end
    join_any
    disable fork;
    if (timeout) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=1 expected=0");
    end
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule